// File: doc/BRIEF.md
# IO Command Privilege and Protection Checker

This block sits beside the IO command path of a 16-bit processor core. It checks every IO command before the command reaches the IO fabric. For each command the core supplies a 16-bit command address, a valid strobe, the command kind and the 4-bit processor state. Bit 15 of the address selects the direction. The lower fifteen bits are sorted into four groups:

- user commands and spare commands, which are forwarded to external logic;
- system-resource commands, which are claimed internally;
- reserved commands, which are refused.

Privileged command kinds issued from a non-zero processor state are refused before any address check is made.

A second, independent port checks memory-page accesses. It compares the processor state with the 4-bit access key of a page. State zero may use every page. Any other state may use only a page whose key equals that state, or a page whose key is the shared value 15. Both decisions are registered and appear one cycle after the request.

Top module: `io_cmd_guard`

## Requirements
- R1: While reset is asserted and after reset, before any request, the outputs ioGrant, ioClaim, ioFault, pageGrant and protFault are 0 and faultCode is 00.
- R2: A valid command with a non-zero procState gives ioFault=1 with faultCode=01 on the next cycle. This holds for every address and every kind, and overrides the reserved-address fault.
- R3: With procState zero, an XIO or VIO command whose address bits [14:0] lie in 2100–2FFF or 4100–4CFF gives ioFault=1 with faultCode=10 on the next cycle.
- R4: With procState zero, an XIO or VIO command whose bits [14:0] lie in 2000–20FF, 4000–40FF or 4D00–52FF gives ioClaim=1 on the next cycle.
- R5: With procState zero, an XIO or VIO command whose bits [14:0] lie in 0000–1FFF, 3000–3FFF or 5300–7FFF gives ioGrant=1 on the next cycle.
- R6: Address bit 15 (the direction bit: 0 output, 1 input) does not change the group, so an input address is classified exactly like the output address with bit 15 cleared.
- R7: cmdKind encodes 00 XIO, 01 VIO, 10 LST and 11 (treated as XIO). An LST command with procState zero is granted whatever its address.
- R8: Exactly one of ioGrant, ioClaim and ioFault is 1 in the cycle after a valid command, and none is 1 in the cycle after a cycle without cmdValid.
- R9: faultCode is 00 whenever ioFault is 0.
- R10: A page request with procState zero gives pageGrant=1 on the next cycle for every key.
- R11: A page request with a non-zero procState gives pageGrant=1 if pageKey equals procState or pageKey is 15. Otherwise it gives protFault=1. Either result appears on the next cycle.
- R12: Page results never drive the IO outputs. IO results never drive the page outputs, including when both requests arrive in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | IO command present this cycle |
| cmdAddr | input | 16 | Command address; bit 15 gives direction |
| cmdKind | input | 2 | 00 XIO, 01 VIO, 10 LST, 11 treated as XIO |
| procState | input | 4 | Processor state field |
| pageValid | input | 1 | Page access check requested |
| pageKey | input | 4 | Access key of the addressed page |
| ioGrant | output | 1 | Command forwarded to external IO |
| ioClaim | output | 1 | Command taken by internal system resources |
| ioFault | output | 1 | Command aborted |
| faultCode | output | 2 | 01 privilege, 10 reserved address, 00 none |
| pageGrant | output | 1 | Page access allowed |
| protFault | output | 1 | Page access denied |

## Verification
The assertions check these properties on every cycle:
- the three IO outcomes are mutually exclusive;
- the fault code agrees with the fault strobe;
- a non-zero state always yields a privilege fault one cycle later;
- an idle cycle yields no IO outcome;
- state zero always obtains its page;
- a denial never coincides with a grant.

The boundaries of each address range need the bench's scenarios. So do the symmetry between input and output addresses, the LST exemption from the address check, and the full sweep of state against key.

// File: rtl/ioguard_pkg.sv
package ioguard_pkg;

  typedef enum logic [1:0] {
    KIND_XIO = 2'd0,
    KIND_VIO = 2'd1,
    KIND_LST = 2'd2,
    KIND_ALT = 2'd3
  } cmdKind_e;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_PRIV = 2'd1,
    FC_RSVD = 2'd2,
    FC_UNUSED = 2'd3
  } faultCode_e;

  typedef enum logic [1:0] {
    GRP_USER  = 2'd0,
    GRP_SPARE = 2'd1,
    GRP_RSVD  = 2'd2,
    GRP_SYS   = 2'd3
  } addrGroup_e;

  // Strobes from the control decision to the output registers
  typedef struct packed {
    logic grant;
    logic claim;
    logic fault;
    logic privErr;
    logic pageOk;
    logic pageDeny;
  } guardStrobes_t;

endpackage

// File: rtl/ioguard_ctrl.sv
module ioguard_ctrl
  import ioguard_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int STATE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic [1:0]         cmdKind,
  input  logic [STATE_W-1:0] procState,
  input  logic               pageValid,
  input  logic [STATE_W-1:0] pageKey,
  output guardStrobes_t      strobes
);

  localparam int OFF_W      = ADDR_W - 1;
  localparam int NUM_RANGES = 7;
  localparam logic [STATE_W-1:0] SHARED_KEY = '1;

  // Non-overlapping offset windows; anything outside them is a user command
  localparam int RANGE_LO [NUM_RANGES] = '{'h2000, 'h2100, 'h3000, 'h4000, 'h4100, 'h4D00, 'h5300};
  localparam int RANGE_HI [NUM_RANGES] = '{'h20FF, 'h2FFF, 'h3FFF, 'h40FF, 'h4CFF, 'h52FF, 'h7FFF};
  localparam addrGroup_e RANGE_GRP [NUM_RANGES] =
    '{GRP_SYS, GRP_RSVD, GRP_SPARE, GRP_SYS, GRP_RSVD, GRP_SYS, GRP_SPARE};

  logic [OFF_W-1:0]      offset;
  logic [NUM_RANGES-1:0] rangeHit;
  addrGroup_e            group;
  logic                  privileged;
  logic                  pageMatch;

  // direction bit is ignored for classification
  assign offset = cmdAddr[OFF_W-1:0];

  for (genvar i = 0; i < NUM_RANGES; i++) begin : gRange
    assign rangeHit[i] = (int'(offset) >= RANGE_LO[i]) && (int'(offset) <= RANGE_HI[i]);
  end

  always_comb begin
    group = GRP_USER;
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (rangeHit[i]) group = RANGE_GRP[i];
    end
  end

  assign privileged = (procState == '0);
  assign pageMatch  = privileged || (pageKey == procState) || (pageKey == SHARED_KEY);

  always_comb begin
    strobes = '0;
    if (cmdValid) begin
      if (!privileged) begin
        strobes.fault   = 1'b1;
        strobes.privErr = 1'b1;
      end else if (cmdKind_e'(cmdKind) == KIND_LST) begin
        strobes.grant = 1'b1;
      end else begin
        unique case (group)
          GRP_RSVD: strobes.fault = 1'b1;
          GRP_SYS:  strobes.claim = 1'b1;
          default:  strobes.grant = 1'b1;
        endcase
      end
    end
    if (pageValid) begin
      strobes.pageOk   = pageMatch;
      strobes.pageDeny = !pageMatch;
    end
  end

  // R8: the decision names at most one outcome
  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.grant, strobes.claim, strobes.fault}));

  // R10: a zero state is never denied a page
  assert_state0_page_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pageValid && procState == '0) |-> !strobes.pageDeny);

  // R3: a reserved-address fault needs supervisor state and an address command
  assert_rsvd_needs_s0_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fault && !strobes.privErr) |-> (procState == '0 && cmdKind != 2'd2));

endmodule

// File: rtl/ioguard_dp.sv
module ioguard_dp
  import ioguard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  guardStrobes_t strobes,
  output logic          ioGrant,
  output logic          ioClaim,
  output logic          ioFault,
  output logic [1:0]    faultCode,
  output logic          pageGrant,
  output logic          protFault
);

  faultCode_e codeNext;

  always_comb begin
    codeNext = FC_NONE;
    if (strobes.fault) codeNext = strobes.privErr ? FC_PRIV : FC_RSVD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioGrant   <= 1'b0;
      ioClaim   <= 1'b0;
      ioFault   <= 1'b0;
      faultCode <= 2'd0;
      pageGrant <= 1'b0;
      protFault <= 1'b0;
    end else begin
      ioGrant   <= strobes.grant;
      ioClaim   <= strobes.claim;
      ioFault   <= strobes.fault;
      faultCode <= 2'(codeNext);
      pageGrant <= strobes.pageOk;
      protFault <= strobes.pageDeny;
    end
  end

  // R9: a code is shown only together with a fault
  assert_code_matches_fault_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ioFault == (faultCode != 2'd0)));

  // R8: the registered outcomes are exclusive
  assert_outputs_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ioGrant, ioClaim, ioFault}));

  // R11: a page is never both granted and denied
  assert_page_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(pageGrant && protFault));

endmodule

// File: rtl/io_cmd_guard.sv
module io_cmd_guard
  import ioguard_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int STATE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic [1:0]         cmdKind,
  input  logic [STATE_W-1:0] procState,
  input  logic               pageValid,
  input  logic [STATE_W-1:0] pageKey,
  output logic               ioGrant,
  output logic               ioClaim,
  output logic               ioFault,
  output logic [1:0]         faultCode,
  output logic               pageGrant,
  output logic               protFault
);

  guardStrobes_t strobes;
  logic          armed;

  ioguard_ctrl #(.ADDR_W(ADDR_W), .STATE_W(STATE_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdAddr   (cmdAddr),
    .cmdKind   (cmdKind),
    .procState (procState),
    .pageValid (pageValid),
    .pageKey   (pageKey),
    .strobes   (strobes)
  );

  ioguard_dp uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .ioGrant   (ioGrant),
    .ioClaim   (ioClaim),
    .ioFault   (ioFault),
    .faultCode (faultCode),
    .pageGrant (pageGrant),
    .protFault (protFault)
  );

  // marks that one full cycle has elapsed since reset, so $past is meaningful
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R2: a user-state command is always a privilege fault one cycle later
  assert_priv_fault_R2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(cmdValid && procState != '0)) |-> (ioFault && faultCode == 2'd1));

  // R8: no outcome without a command in the previous cycle
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(cmdValid)) |-> !(ioGrant || ioClaim || ioFault));

  // R10: state zero always obtains its page
  assert_page_state0_R10: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(pageValid && procState == '0)) |-> pageGrant);

  // R12: page outputs only follow page requests
  assert_page_isolated_R12: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(pageValid)) |-> !(pageGrant || protFault));

endmodule

// File: tb/tb_io_cmd_guard.sv
`timescale 1ns/1ps
module tb_io_cmd_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [15:0] cmdAddr = '0;
  logic [1:0]  cmdKind = '0;
  logic [3:0]  procState = '0;
  logic        pageValid = 1'b0;
  logic [3:0]  pageKey = '0;
  logic        ioGrant, ioClaim, ioFault, pageGrant, protFault;
  logic [1:0]  faultCode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  io_cmd_guard dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .cmdKind(cmdKind), .procState(procState), .pageValid(pageValid),
    .pageKey(pageKey), .ioGrant(ioGrant), .ioClaim(ioClaim), .ioFault(ioFault),
    .faultCode(faultCode), .pageGrant(pageGrant), .protFault(protFault)
  );

  // {kind[31:30], state[29:26], addr[25:10], grant/claim/fault[9:7], code[6:5], req[4:1], pad[0]}
  localparam int NV = 25;
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 4'd0,  16'h0000, 3'b100, 2'd0, 4'd5,  1'b0}, // R5 user low edge
    {2'd0, 4'd0,  16'h1FFF, 3'b100, 2'd0, 4'd5,  1'b0}, // R5 user high edge
    {2'd0, 4'd0,  16'h2000, 3'b010, 2'd0, 4'd4,  1'b0}, // R4
    {2'd1, 4'd0,  16'h20FF, 3'b010, 2'd0, 4'd4,  1'b0}, // R4
    {2'd0, 4'd0,  16'h2100, 3'b001, 2'd2, 4'd3,  1'b0}, // R3
    {2'd0, 4'd0,  16'h2FFF, 3'b001, 2'd2, 4'd3,  1'b0}, // R3
    {2'd0, 4'd0,  16'h3000, 3'b100, 2'd0, 4'd5,  1'b0}, // R5 spare
    {2'd0, 4'd0,  16'h4000, 3'b010, 2'd0, 4'd4,  1'b0}, // R4
    {2'd0, 4'd0,  16'h40FF, 3'b010, 2'd0, 4'd4,  1'b0}, // R4
    {2'd1, 4'd0,  16'h4100, 3'b001, 2'd2, 4'd3,  1'b0}, // R3
    {2'd0, 4'd0,  16'h4CFF, 3'b001, 2'd2, 4'd3,  1'b0}, // R3
    {2'd0, 4'd0,  16'h4D00, 3'b010, 2'd0, 4'd4,  1'b0}, // R4
    {2'd0, 4'd0,  16'h52FF, 3'b010, 2'd0, 4'd4,  1'b0}, // R4
    {2'd0, 4'd0,  16'h5300, 3'b100, 2'd0, 4'd5,  1'b0}, // R5 spare
    {2'd0, 4'd0,  16'h7FFF, 3'b100, 2'd0, 4'd5,  1'b0}, // R5
    {2'd1, 4'd0,  16'hA100, 3'b001, 2'd2, 4'd6,  1'b0}, // R6 input reserved
    {2'd0, 4'd0,  16'hC0FF, 3'b010, 2'd0, 4'd6,  1'b0}, // R6 input system
    {2'd0, 4'd0,  16'hD2FF, 3'b010, 2'd0, 4'd6,  1'b0}, // R6 input page regs
    {2'd0, 4'd0,  16'hFFFF, 3'b100, 2'd0, 4'd6,  1'b0}, // R6 input spare
    {2'd0, 4'd0,  16'hB000, 3'b100, 2'd0, 4'd6,  1'b0}, // R6 input spare
    {2'd0, 4'd5,  16'h0000, 3'b001, 2'd1, 4'd2,  1'b0}, // R2
    {2'd1, 4'd15, 16'h2100, 3'b001, 2'd1, 4'd2,  1'b0}, // R2 priority over reserved
    {2'd2, 4'd1,  16'h0000, 3'b001, 2'd1, 4'd2,  1'b0}, // R2 LST in user state
    {2'd2, 4'd0,  16'h2100, 3'b100, 2'd0, 4'd7,  1'b0}, // R7 LST skips address check
    {2'd3, 4'd0,  16'h2100, 3'b001, 2'd2, 4'd7,  1'b0}  // R7 kind 11 acts as XIO
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic logic [7:0] ioBundle();
    return {3'b0, ioGrant, ioClaim, ioFault, faultCode};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      finishRun();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", {ioBundle()[4:0], pageGrant, protFault, 1'b0}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1", {ioBundle()[4:0], pageGrant, protFault, 1'b0}, 8'h00);

    // vector table: R2..R7, and R8/R9 through the bundle
    for (int i = 0; i < NV; i++) begin
      cmdKind   = VEC[i][31:30];
      procState = VEC[i][29:26];
      cmdAddr   = VEC[i][25:10];
      cmdValid  = 1'b1;
      @(negedge clk);
      cmdValid  = 1'b0;
      chk($sformatf("R%0d vec%0d", VEC[i][4:1], i), ioBundle(), {3'b0, VEC[i][9:5]});
    end

    // R8: idle cycle produces nothing
    @(negedge clk);
    chk("R8 idle", ioBundle(), 8'h00);

    // R10/R11 sweep, R12 IO outputs stay quiet
    procState = 4'd0;
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 16; k++) begin
        logic ok;
        ok = (s == 0) || (k == s) || (k == 15);
        procState = 4'(s);
        pageKey   = 4'(k);
        pageValid = 1'b1;
        @(negedge clk);
        pageValid = 1'b0;
        chk(s == 0 ? "R10" : "R11",
            {3'b0, pageGrant, protFault, ioGrant, ioClaim, ioFault},
            {3'b0, ok, !ok, 3'b000});
      end
    end

    // R12: simultaneous denied page and granted command
    procState = 4'd3;
    pageKey   = 4'd4;
    cmdKind   = 2'd0;
    cmdAddr   = 16'h0010;
    cmdValid  = 1'b1;
    pageValid = 1'b1;
    @(negedge clk);
    cmdValid  = 1'b0;
    pageValid = 1'b0;
    chk("R12 both", {2'b0, ioBundle()[4:0], protFault}, {2'b0, 3'b001, 2'd1, 1'b1});
    procState = 4'd0;
    cmdValid  = 1'b1;
    pageValid = 1'b1;
    @(negedge clk);
    cmdValid  = 1'b0;
    pageValid = 1'b0;
    chk("R12 grants", {2'b0, ioBundle()[4:0], pageGrant}, {2'b0, 3'b100, 2'd0, 1'b1});

    // R1: reset mid-run clears outputs
    cmdValid = 1'b1;
    @(negedge clk);
    rstN = 1'b0;
    cmdValid = 1'b0;
    #1;
    chk("R1 async", {ioBundle()[4:0], pageGrant, protFault, 1'b0}, 8'h00);

    done = 1;
    finishRun();
  end

endmodule